// File: doc/BRIEF.md
# Balanced Nibble Codec

The block maps a 4-bit value onto an 8-bit codeword that always holds exactly four ones, because every data bit sits next to, or is spread against, its own inverse. Two placements of the true and inverted bits are offered. A one-bit layout input chooses between them for every operation in the same cycle.

The block has three functions. A combinational encoder turns a nibble into its codeword. A combinational checker reads one received word, sorts it into VALID, INVALID or NULL, and returns the nibble it carries. A registered XOR unit takes two encoded operands, decodes them, combines the nibbles and re-encodes the result in the same layout. If either operand is not a legal codeword, the XOR unit gives the all-zero word instead of a result, so a corrupted input cannot turn into a legal-looking output.

Top module: `nibcode_top`

## Requirements
- R1: With `lay_i`=0, `enc_o` bits 7..0 are n3, ~n3, n2, ~n2, n1, ~n1, n0, ~n0, where n is `nib_i`.
- R2: With `lay_i`=1, `enc_o` bits 7..0 are n0, ~n2, n1, n3, ~n1, n2, ~n0, ~n3.
- R3: `enc_o` has a Hamming weight of exactly 4 for every nibble and both layouts.
- R4: When `opa_i` is all zero, `chk_o` is NULL (2'd0) and `dec_o` is 0.
- R5: When every true/inverse bit pair of `opa_i` under the selected layout differs, `chk_o` is VALID (2'd1) and `dec_o` is the nibble that the word encodes.
- R6: Any other non-zero word gives `chk_o` INVALID (2'd2) and `dec_o` 0. This includes weight-4 words that are legal only in the other layout.
- R7: One clock after both operands are VALID, `xor_o` is the codeword, in the layout sampled with them, of the XOR of their nibbles, and `xor_st_o` is VALID.
- R8: One clock after either operand is INVALID or NULL, `xor_o` is 0 and `xor_st_o` is NULL.
- R9: While `rst_ni` is low, `xor_o` is 0 and `xor_st_o` is NULL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nib_i | input | 4 | Nibble to encode |
| lay_i | input | 1 | Layout select: 0 = adjacent pairs, 1 = spread pairs |
| enc_o | output | 8 | Codeword for `nib_i` |
| opa_i | input | 8 | Encoded operand A; also the word that is checked |
| opb_i | input | 8 | Encoded operand B |
| dec_o | output | 4 | Decoded nibble of `opa_i` (0 unless VALID) |
| chk_o | output | 2 | Class of `opa_i`: 0 NULL, 1 VALID, 2 INVALID |
| xor_o | output | 8 | Registered encoded XOR result |
| xor_st_o | output | 2 | Registered class of the XOR result |

## Verification
The encoder, checker and decoded nibble respond in the same cycle. The bench drives inputs on the falling edge and compares these outputs at the next falling edge, while the inputs are still held. The XOR result and its status are due one rising edge after their operands. The reference model stores the expectation computed from each applied vector, including the layout bit, and compares it at the next falling edge. A layout change in the following cycle therefore has to leave the registered result alone.

// File: rtl/nibcode_pkg.sv
package nibcode_pkg;
  localparam int NIB_W  = 4;
  localparam int WORD_W = 2 * NIB_W;
  localparam int N_OPS  = 2;

  typedef enum logic [1:0] {
    ST_NULL    = 2'd0,
    ST_VALID   = 2'd1,
    ST_INVALID = 2'd2
  } cw_status_e;
endpackage

// File: rtl/nibcode_enc.sv
module nibcode_enc
  import nibcode_pkg::*;
(
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              lay_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_adj, word_spr;

  for (genvar i = 0; i < NIB_W; i++) begin : g_adj
    assign word_adj[2*i+1] = nib_i[i];
    assign word_adj[2*i]   = ~nib_i[i];
  end

  // spread layout, fixed for a 4-bit nibble
  assign word_spr = {nib_i[0], ~nib_i[2], nib_i[1], nib_i[3],
                     ~nib_i[1], nib_i[2], ~nib_i[0], ~nib_i[3]};

  assign word_o = lay_i ? word_spr : word_adj;
endmodule

// File: rtl/nibcode_chk.sv
module nibcode_chk
  import nibcode_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              lay_i,
  output cw_status_e        st_o,
  output logic [NIB_W-1:0]  nib_o
);
  logic [NIB_W-1:0] tru_adj, cmp_adj, tru_spr, cmp_spr, tru, cmp;
  logic             pairs_ok;

  for (genvar i = 0; i < NIB_W; i++) begin : g_adj
    assign tru_adj[i] = word_i[2*i+1];
    assign cmp_adj[i] = word_i[2*i];
  end

  assign tru_spr = {word_i[4], word_i[2], word_i[5], word_i[7]};
  assign cmp_spr = {word_i[0], word_i[6], word_i[3], word_i[1]};

  assign tru = lay_i ? tru_spr : tru_adj;
  assign cmp = lay_i ? cmp_spr : cmp_adj;
  assign pairs_ok = &(tru ^ cmp);

  always_comb begin
    if (word_i == '0)  st_o = ST_NULL;
    else if (pairs_ok) st_o = ST_VALID;
    else               st_o = ST_INVALID;
  end

  assign nib_o = (st_o == ST_VALID) ? tru : '0;
endmodule

// File: rtl/nibcode_top.sv
module nibcode_top
  import nibcode_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  nib_i,
  input  logic        lay_i,
  output logic [7:0]  enc_o,
  input  logic [7:0]  opa_i,
  input  logic [7:0]  opb_i,
  output logic [3:0]  dec_o,
  output logic [1:0]  chk_o,
  output logic [7:0]  xor_o,
  output logic [1:0]  xor_st_o
);
  logic [WORD_W-1:0] op_w   [N_OPS];
  cw_status_e        op_st  [N_OPS];
  logic [NIB_W-1:0]  op_nib [N_OPS];
  logic              ops_ok;
  logic [NIB_W-1:0]  res_nib;
  logic [WORD_W-1:0] res_word, xor_q;
  cw_status_e        xst_q;

  assign op_w[0] = opa_i;
  assign op_w[1] = opb_i;

  nibcode_enc u_enc (.nib_i(nib_i), .lay_i(lay_i), .word_o(enc_o));

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    nibcode_chk u_chk (
      .word_i(op_w[g]), .lay_i(lay_i), .st_o(op_st[g]), .nib_o(op_nib[g])
    );
  end

  assign dec_o = op_nib[0];
  assign chk_o = op_st[0];

  assign ops_ok  = (op_st[0] == ST_VALID) && (op_st[1] == ST_VALID);
  assign res_nib = op_nib[0] ^ op_nib[1];

  nibcode_enc u_renc (.nib_i(res_nib), .lay_i(lay_i), .word_o(res_word));

  // layout is captured with the operands through res_word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xor_q <= '0;
      xst_q <= ST_NULL;
    end else if (ops_ok) begin
      xor_q <= res_word;
      xst_q <= ST_VALID;
    end else begin
      xor_q <= '0;
      xst_q <= ST_NULL;
    end
  end

  assign xor_o    = xor_q;
  assign xor_st_o = xst_q;

  // R3
  enc_weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(enc_o) == 4);
  // R5
  valid_weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_o == ST_VALID) |-> ($countones(opa_i) == 4));
  // R4
  null_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_o == ST_NULL) |-> (dec_o == '0 && opa_i == '0));
  // R6
  invalid_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_o == ST_INVALID) |-> (opa_i != '0 && dec_o == '0));
  // R7
  xor_weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xor_st_o == ST_VALID) |-> ($countones(xor_o) == 4));
  // R8
  xor_null_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_st[0] != ST_VALID || op_st[1] != ST_VALID) |=>
      (xor_st_o == ST_NULL && xor_o == '0));
endmodule

// File: tb/nibcode_top_test.sv
module nibcode_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] nib_i = '0;
  logic       lay_i = 1'b0;
  logic [7:0] opa_i = '0;
  logic [7:0] opb_i = '0;
  logic [7:0] enc_o, xor_o;
  logic [3:0] dec_o;
  logic [1:0] chk_o, xor_st_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] exp_xor;
  logic [1:0] exp_xst;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  nibcode_top uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .nib_i(nib_i), .lay_i(lay_i),
    .enc_o(enc_o), .opa_i(opa_i), .opb_i(opb_i), .dec_o(dec_o),
    .chk_o(chk_o), .xor_o(xor_o), .xor_st_o(xor_st_o)
  );

  function automatic logic [7:0] ref_enc(input logic [3:0] n, input logic l);
    logic [7:0] w;
    if (!l) begin
      w = '0;
      for (int k = 0; k < 4; k++) begin
        w = w << 2;
        w[1] = n[3-k];
        w[0] = !n[3-k];
      end
    end else begin
      w = {n[0], !n[2], n[1], n[3], !n[1], n[2], !n[0], !n[3]};
    end
    return w;
  endfunction

  // classify by exhaustive search over the 16 legal codewords
  function automatic logic [1:0] ref_cls(input logic [7:0] w, input logic l);
    if (w == 8'h00) return 2'd0;
    for (int v = 0; v < 16; v++)
      if (ref_enc(v[3:0], l) == w) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [3:0] ref_dec(input logic [7:0] w, input logic l);
    for (int v = 0; v < 16; v++)
      if (ref_enc(v[3:0], l) == w) return v[3:0];
    return 4'd0;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (nib=%h lay=%0d a=%h b=%h)",
               req, act, exp, nib_i, lay_i, opa_i, opb_i);
    end
  endtask

  // compare at falling edge, then apply the next vector
  task automatic step(input logic [3:0] n, input logic l, input logic [7:0] a,
                      input logic [7:0] b);
    logic [1:0] ca, cb;
    @(negedge clk_i);
    chk(lay_i ? "R2" : "R1", enc_o, ref_enc(nib_i, lay_i));
    chk("R3", 8'($countones(enc_o)), 8'd4);
    case (ref_cls(opa_i, lay_i))
      2'd0: begin chk("R4", 8'(chk_o), 8'd0); chk("R4", 8'(dec_o), 8'd0); end
      2'd1: begin chk("R5", 8'(chk_o), 8'd1);
                  chk("R5", 8'(dec_o), 8'(ref_dec(opa_i, lay_i))); end
      default: begin chk("R6", 8'(chk_o), 8'd2); chk("R6", 8'(dec_o), 8'd0); end
    endcase
    chk(exp_xst == 2'd1 ? "R7" : "R8", xor_o, exp_xor);
    chk(exp_xst == 2'd1 ? "R7" : "R8", 8'(xor_st_o), 8'(exp_xst));
    nib_i = n; lay_i = l; opa_i = a; opb_i = b;
    ca = ref_cls(a, l);
    cb = ref_cls(b, l);
    if (ca == 2'd1 && cb == 2'd1) begin
      exp_xor = ref_enc(ref_dec(a, l) ^ ref_dec(b, l), l);
      exp_xst = 2'd1;
    end else begin
      exp_xor = 8'h00;
      exp_xst = 2'd0;
    end
  endtask

  initial begin
    exp_xor = 8'h00;
    exp_xst = 2'd0;
    #(CLK_PERIOD*2);
    // R9: reset state
    chk("R9", xor_o, 8'h00);
    chk("R9", 8'(xor_st_o), 8'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // all legal operand pairs, both layouts
    for (int l = 0; l < 2; l++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          step(4'(a ^ b), l[0], ref_enc(a[3:0], l[0]), ref_enc(b[3:0], l[0]));
    // every word as A, then as B, against a legal partner
    for (int l = 0; l < 2; l++)
      for (int w = 0; w < 256; w++)
        step(w[3:0], l[0], w[7:0], ref_enc(w[7:4], l[0]));
    for (int l = 0; l < 2; l++)
      for (int w = 0; w < 256; w++)
        step(w[7:4], l[0], ref_enc(w[3:0], l[0]), w[7:0]);
    // R6: word legal only in the other layout
    step(4'h0, 1'b1, ref_enc(4'h0, 1'b0), ref_enc(4'h3, 1'b1));
    step(4'h5, 1'b0, ref_enc(4'h6, 1'b1), ref_enc(4'h3, 1'b0));
    // random mix with layout toggling every cycle
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a, b;
      logic l;
      l = 1'($urandom);
      a = ($urandom % 2) ? ref_enc(4'($urandom), l) : 8'($urandom);
      b = ($urandom % 4) ? ref_enc(4'($urandom), l) : 8'($urandom % 2);
      step(4'($urandom), l, a, b);
    end
    step(4'h0, 1'b0, 8'h00, 8'h00);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule